// File: doc/BRIEF.md
# Sectored Page Read ECC Sequencer

This block steps a flash page read with hardware error correction through the page one sector at a time. A sector is 512 bytes. For each sector it re-arms the ECC engine, asks a data mover to read the sector's bytes, and asks the mover for that sector's check bytes in the spare area. It then hands the sector to the correction stage that matches the selected scheme. The spare-area cursor starts two bytes past the end of the main area, which skips the bad-block marker. After each sector the cursor moves on by a stride set by the ECC scheme and the bus width.

In Hamming mode the sequencer waits for the engine's write-FIFO-empty flag, latches the 24-bit computed code for the Hamming corrector, reads the check bytes and starts that corrector. In the BCH modes it reads the check bytes and waits for the decoder's ready flag. It then decodes the decoder status and issues one bit-flip request for each reported error position that lies inside the sector. A wait that lasts longer than a timeout counted in clock cycles ends the read with a failure code. So does an uncorrectable sector or a failed Hamming correction. A done pulse marks a page whose sectors have all been handled.

Top module: `pgrd_ecc_seq`

## Requirements
- R1: The number of sectors is page_size/512, rounded down. For sector s, in ascending order, the block issues one data read with rd_col = s*512 and rd_len = 512. The first rd_valid is high in the second cycle after the cycle in which start is sampled.
- R2: A page_size below 512 gives a done pulse in the cycle right after start and issues no reads. err_code is 0 after such a page.
- R3: For each sector, the check-byte read follows the data read. Its rd_col is page_size + 2 + s*stride and its rd_len is the stride. ecc_sel encodes the scheme as 00 Hamming, 01 BCH4, 10 BCH8 and 11 BCH4. The stride is 3, 7, 13 and 7 respectively, plus 1 when bus16 is 1.
- R4: ecc_en is low in the cycle before each data read and high during it, so it rises exactly once per started sector. ecc_dec is 1 for the BCH codes and 0 for Hamming, and it does not change during a read.
- R5: In Hamming mode, ham_code is captured on the clock edge at which fifo_empty is high and is then held on code_q. corr_start pulses after the check-byte read completes. corr_fail sampled with corr_done aborts the read with err_code 11.
- R6: In the BCH modes, the block samples bch_flags when dec_ready is high after the check-byte read. If bit 1 (error found) is 0, the sector is clean and no flips are issued. If bit 1 is 1 and bit 0 (uncorrectable) is 1, the read aborts with err_code 10.
- R7: The error count is bch_flags[7:4], capped at 8. Position k sits in 32-bit word k/2 of bch_pos, at bits 12:0 for even k and bits 28:16 for odd k. For each k below the count, a position p under 4096 produces one flip_valid cycle with flip_addr = s*512 + p/8 and flip_mask = 1 << (p mod 8). Positions of 4096 or more are skipped.
- R8: If fifo_empty or dec_ready stays low for CLK_MHZ*TIMEOUT_US cycles, the read aborts with err_code 01. A flag that arrives inside that window lets the read continue.
- R9: done pulses for one cycle only after the last sector, with err_code 00. fail pulses for one cycle on any abort. The two never occur together. busy is low in the cycle that follows either pulse, and err_code holds until the next accepted start.
- R10: A start while busy is ignored, together with the page_size and mode present at that time.
- R11: After reset the block is idle, with busy, done, fail, rd_valid, ecc_en, corr_start and flip_valid low and err_code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page read (accepted when idle) |
| page_size | input | COL_W | Main-area size in bytes |
| ecc_sel | input | 2 | ECC scheme code |
| bus16 | input | 1 | 16-bit flash bus |
| busy | output | 1 | Read in progress |
| done | output | 1 | Page complete pulse |
| fail | output | 1 | Abort pulse |
| err_code | output | 2 | 00 ok, 01 timeout, 10 uncorrectable, 11 Hamming fail |
| rd_valid | output | 1 | Column-read request pulse |
| rd_col | output | COL_W | Read start column |
| rd_len | output | SECT_LOG2+1 | Read length in bytes |
| rd_done | input | 1 | Mover finished the request |
| ecc_en | output | 1 | ECC engine enable |
| ecc_dec | output | 1 | Engine in decode direction (BCH) |
| fifo_empty | input | 1 | Engine write FIFO empty (Hamming) |
| ham_code | input | 24 | Computed Hamming code |
| code_q | output | 24 | Captured code for the corrector |
| dec_ready | input | 1 | BCH decode result ready |
| bch_flags | input | 32 | BCH status: bit0 uncorrectable, bit1 found, 7:4 count |
| bch_pos | input | NPOS*16 | Packed BCH error positions |
| corr_start | output | 1 | Start Hamming corrector |
| corr_done | input | 1 | Hamming corrector finished |
| corr_fail | input | 1 | Hamming corrector found an uncorrectable pattern |
| flip_valid | output | 1 | Bit-flip request |
| flip_addr | output | COL_W | Byte offset in the page to flip |
| flip_mask | output | 8 | Bit to flip within the byte |

## Verification
The first data read is due in the second cycle after start is sampled, because one cycle is spent with the engine disabled. For pages shorter than a sector, done is due in the very next cycle. The bench samples at those exact falling edges. Every later result waits on a handshake with a randomized delay, so the bench records each request, flip and end pulse at the falling edge where it is seen. It then compares these logs in order with lists built from page size, scheme and bus width. The Hamming code is checked at the corrector handshake, after the bench has put random values on ham_code, so that a capture taken on the wrong edge shows up.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'b00,
    ERR_TIMEOUT = 2'b01,
    ERR_UNCORR  = 2'b10,
    ERR_HAMFAIL = 2'b11
  } err_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_DREQ, ST_DWAIT, ST_HWAIT, ST_EREQ, ST_EWAIT,
    ST_CSTART, ST_CWAIT, ST_BWAIT, ST_BEVAL, ST_FLIP, ST_NEXT,
    ST_DONE, ST_FAIL
  } st_e;

  localparam int MARKER_BYTES = 2;

  // Check bytes per sector for a scheme code and bus width.
  function automatic logic [3:0] ecc_stride(input logic [1:0] sel, input logic wide);
    logic [3:0] base;
    case (sel)
      2'b00:   base = 4'd3;
      2'b10:   base = 4'd13;
      default: base = 4'd7;
    endcase
    return base + {3'b000, wide};
  endfunction

  function automatic logic sel_is_bch(input logic [1:0] sel);
    return sel != 2'b00;
  endfunction

endpackage

// File: rtl/pgrd_cursor.sv
module pgrd_cursor #(
  parameter int COL_W     = 14,
  parameter int SECT_LOG2 = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic                       adv,
  input  logic [COL_W-1:0]           page_size,
  input  logic [3:0]                 stride,
  output logic [COL_W-SECT_LOG2-1:0] step,
  output logic [COL_W-1:0]           data_col,
  output logic [COL_W-1:0]           ecc_col,
  output logic                       last
);
  localparam int STEP_W = COL_W - SECT_LOG2;

  logic [STEP_W-1:0] step_q, step_d, nst_q, nst_d;
  logic [COL_W-1:0]  cur_q, cur_d;

  always_comb begin
    step_d = step_q;
    nst_d  = nst_q;
    cur_d  = cur_q;
    if (load) begin
      step_d = '0;
      nst_d  = page_size[COL_W-1:SECT_LOG2];
      cur_d  = page_size + COL_W'(pgrd_pkg::MARKER_BYTES);
    end else if (adv) begin
      step_d = step_q + 1'b1;
      cur_d  = cur_q + COL_W'(stride);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      nst_q  <= '0;
      cur_q  <= '0;
    end else if (load || adv) begin
      step_q <= step_d;
      nst_q  <= nst_d;
      cur_q  <= cur_d;
    end
  end

  assign step     = step_q;
  assign data_col = {step_q, {SECT_LOG2{1'b0}}};
  assign ecc_col  = cur_q;
  assign last     = (step_q == nst_q - 1'b1);
endmodule

// File: rtl/pgrd_tmo.sv
module pgrd_tmo #(
  parameter int CNT_MAX = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(CNT_MAX + 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run)                        cnt_d = '0;
    else if (cnt_q == TW'(CNT_MAX))  cnt_d = cnt_q;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == TW'(CNT_MAX - 1));
endmodule

// File: rtl/pgrd_flips.sv
module pgrd_flips #(
  parameter int POS_W     = 13,
  parameter int NPOS      = 8,
  parameter int SECT_LOG2 = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               adv,
  input  logic [31:0]        flags_in,
  input  logic [NPOS*16-1:0] pos_in,
  output logic [POS_W-1:0]   cur_pos,
  output logic               cur_ok,
  output logic               is_last,
  output logic               found,
  output logic               uncorr,
  output logic               any
);
  localparam int IDX_W     = $clog2(NPOS);
  localparam int SECT_BITS = (1 << SECT_LOG2) * 8;

  logic [7:0]         flg_q;
  logic [NPOS*16-1:0] words_q;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [POS_W-1:0]   pos_a [NPOS];
  logic [3:0]         cnt4;
  logic [4:0]         ncap;

  always_comb begin
    idx_d = idx_q;
    if (load)     idx_d = '0;
    else if (adv) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q   <= '0;
      words_q <= '0;
      idx_q   <= '0;
    end else begin
      if (load) begin
        flg_q   <= flags_in[7:0];
        words_q <= pos_in;
      end
      if (load || adv) idx_q <= idx_d;
    end
  end

  generate
    for (genvar i = 0; i < NPOS; i++) begin : g_pos
      assign pos_a[i] = words_q[(i/2)*32 + (i%2)*16 +: POS_W];
    end
  endgenerate

  assign cnt4    = flg_q[7:4];
  assign ncap    = (32'(cnt4) > NPOS) ? 5'(NPOS) : {1'b0, cnt4};
  assign cur_pos = pos_a[idx_q];
  assign cur_ok  = (32'(cur_pos) < SECT_BITS);
  assign is_last = (5'(idx_q) + 5'd1) >= ncap;
  assign found   = flg_q[1];
  assign uncorr  = flg_q[0];
  assign any     = (ncap != 5'd0);
endmodule

// File: rtl/pgrd_ecc_seq.sv
module pgrd_ecc_seq
  import pgrd_pkg::*;
#(
  parameter int COL_W      = 14,
  parameter int SECT_LOG2  = 9,
  parameter int POS_W      = 13,
  parameter int NPOS       = 8,
  parameter int CLK_MHZ    = 200,
  parameter int TIMEOUT_US = 10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [COL_W-1:0]     page_size,
  input  logic [1:0]           ecc_sel,
  input  logic                 bus16,
  output logic                 busy,
  output logic                 done,
  output logic                 fail,
  output logic [1:0]           err_code,
  output logic                 rd_valid,
  output logic [COL_W-1:0]     rd_col,
  output logic [SECT_LOG2:0]   rd_len,
  input  logic                 rd_done,
  output logic                 ecc_en,
  output logic                 ecc_dec,
  input  logic                 fifo_empty,
  input  logic [23:0]          ham_code,
  output logic [23:0]          code_q,
  input  logic                 dec_ready,
  input  logic [31:0]          bch_flags,
  input  logic [NPOS*16-1:0]   bch_pos,
  output logic                 corr_start,
  input  logic                 corr_done,
  input  logic                 corr_fail,
  output logic                 flip_valid,
  output logic [COL_W-1:0]     flip_addr,
  output logic [7:0]           flip_mask
);
  localparam int LEN_W      = SECT_LOG2 + 1;
  localparam int SECT_BYTES = 1 << SECT_LOG2;
  localparam int TMO_CYC    = CLK_MHZ * TIMEOUT_US;
  localparam int STEP_W     = COL_W - SECT_LOG2;

  st_e         st_q, st_d;
  err_e        err_q, err_d;
  logic [1:0]  sel_q, sel_d;
  logic        wide_q, wide_d;
  logic [23:0] code_r, code_d;
  logic        code_en;
  logic        bch;
  logic [3:0]  stride;

  logic              cur_load, cur_adv, cur_last;
  logic [STEP_W-1:0] cur_step;
  logic [COL_W-1:0]  data_col, ecc_col;
  logic              w_load, w_adv;
  logic [POS_W-1:0]  w_pos;
  logic              w_ok, w_last, w_found, w_uncorr, w_any;
  logic              tmo_run, tmo_exp;

  assign bch    = sel_is_bch(sel_q);
  assign stride = ecc_stride(sel_q, wide_q);

  pgrd_cursor #(.COL_W(COL_W), .SECT_LOG2(SECT_LOG2)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(cur_load), .adv(cur_adv),
    .page_size(page_size), .stride(stride), .step(cur_step),
    .data_col(data_col), .ecc_col(ecc_col), .last(cur_last)
  );

  pgrd_flips #(.POS_W(POS_W), .NPOS(NPOS), .SECT_LOG2(SECT_LOG2)) u_flips (
    .clk(clk), .rst_n(rst_n), .load(w_load), .adv(w_adv),
    .flags_in(bch_flags), .pos_in(bch_pos), .cur_pos(w_pos),
    .cur_ok(w_ok), .is_last(w_last), .found(w_found),
    .uncorr(w_uncorr), .any(w_any)
  );

  assign tmo_run = (st_q == ST_HWAIT) || (st_q == ST_BWAIT);

  pgrd_tmo #(.CNT_MAX(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(tmo_run), .expire(tmo_exp)
  );

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    err_d    = err_q;
    sel_d    = sel_q;
    wide_d   = wide_q;
    code_d   = code_r;
    code_en  = 1'b0;
    cur_load = 1'b0;
    cur_adv  = 1'b0;
    w_load   = 1'b0;
    w_adv    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          sel_d    = ecc_sel;
          wide_d   = bus16;
          err_d    = ERR_NONE;
          cur_load = 1'b1;
          st_d     = (page_size[COL_W-1:SECT_LOG2] == '0) ? ST_DONE : ST_ARM;
        end
      end
      ST_ARM:  st_d = ST_DREQ;
      ST_DREQ: st_d = ST_DWAIT;
      ST_DWAIT: begin
        if (rd_done) st_d = bch ? ST_EREQ : ST_HWAIT;
      end
      ST_HWAIT: begin
        if (fifo_empty) begin
          code_d  = ham_code;
          code_en = 1'b1;
          st_d    = ST_EREQ;
        end else if (tmo_exp) begin
          err_d = ERR_TIMEOUT;
          st_d  = ST_FAIL;
        end
      end
      ST_EREQ: st_d = ST_EWAIT;
      ST_EWAIT: begin
        if (rd_done) st_d = bch ? ST_BWAIT : ST_CSTART;
      end
      ST_CSTART: st_d = ST_CWAIT;
      ST_CWAIT: begin
        if (corr_done) begin
          if (corr_fail) begin
            err_d = ERR_HAMFAIL;
            st_d  = ST_FAIL;
          end else begin
            st_d = ST_NEXT;
          end
        end
      end
      ST_BWAIT: begin
        if (dec_ready) begin
          w_load = 1'b1;
          st_d   = ST_BEVAL;
        end else if (tmo_exp) begin
          err_d = ERR_TIMEOUT;
          st_d  = ST_FAIL;
        end
      end
      ST_BEVAL: begin
        if (!w_found)      st_d = ST_NEXT;
        else if (w_uncorr) begin
          err_d = ERR_UNCORR;
          st_d  = ST_FAIL;
        end
        else if (!w_any)   st_d = ST_NEXT;
        else               st_d = ST_FLIP;
      end
      ST_FLIP: begin
        if (w_last) st_d = ST_NEXT;
        else        w_adv = 1'b1;
      end
      ST_NEXT: begin
        if (cur_last) st_d = ST_DONE;
        else begin
          cur_adv = 1'b1;
          st_d    = ST_ARM;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      ST_FAIL: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      err_q  <= ERR_NONE;
      sel_q  <= 2'b00;
      wide_q <= 1'b0;
      code_r <= '0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      sel_q  <= sel_d;
      wide_q <= wide_d;
      if (code_en) code_r <= code_d;
    end
  end

  // Outputs decoded from state
  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign fail       = (st_q == ST_FAIL);
  assign err_code   = err_q;
  assign rd_valid   = (st_q == ST_DREQ) || (st_q == ST_EREQ);
  assign rd_col     = (st_q == ST_EREQ) ? ecc_col : data_col;
  assign rd_len     = (st_q == ST_EREQ) ? LEN_W'(stride) : LEN_W'(SECT_BYTES);
  assign ecc_en     = (st_q == ST_DREQ) || (st_q == ST_DWAIT) || (st_q == ST_HWAIT) ||
                      (bch && ((st_q == ST_EREQ) || (st_q == ST_EWAIT) || (st_q == ST_BWAIT)));
  assign ecc_dec    = bch;
  assign code_q     = code_r;
  assign corr_start = (st_q == ST_CSTART);
  assign flip_valid = (st_q == ST_FLIP) && w_ok;
  assign flip_addr  = data_col + COL_W'(w_pos[POS_W-1:3]);
  assign flip_mask  = 8'd1 << w_pos[2:0];
endmodule

// File: rtl/pgrd_ecc_seq_chk.sv
module pgrd_ecc_seq_chk #(
  parameter int COL_W     = 14,
  parameter int SECT_LOG2 = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic [1:0]         err_code,
  input logic               rd_valid,
  input logic [COL_W-1:0]   rd_col,
  input logic [SECT_LOG2:0] rd_len,
  input logic               ecc_en,
  input logic               ecc_dec,
  input logic               corr_start,
  input logic               flip_valid,
  input logic [7:0]         flip_mask
);
  localparam logic [SECT_LOG2:0] SLEN = (SECT_LOG2+1)'(1 << SECT_LOG2);

  assert_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_len == SLEN) |-> (ecc_en && !$past(ecc_en)));

  assert_data_col_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_len == SLEN) |-> (rd_col[SECT_LOG2-1:0] == '0));

  assert_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_len != SLEN) |->
      (rd_len == 3 || rd_len == 4 || rd_len == 7 || rd_len == 8 ||
       rd_len == 13 || rd_len == 14));

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ecc_dec));

  assert_flip_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flip_valid |-> ($countones(flip_mask) == 1));

  assert_single_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fail, rd_valid, corr_start, flip_valid}));

  assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> !busy);

  assert_end_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail |-> err_code != 2'b00) and (done |-> err_code == 2'b00));
endmodule

bind pgrd_ecc_seq pgrd_ecc_seq_chk #(.COL_W(COL_W), .SECT_LOG2(SECT_LOG2)) u_chk (.*);

// File: tb/pgrd_ecc_seq_bench.sv
`timescale 1ns/1ps
module pgrd_ecc_seq_bench;
  localparam int COL_W = 14;
  localparam int NPOS  = 8;
  localparam int TMO   = 40;

  logic clk, rst_n, start, bus16;
  logic [COL_W-1:0] page_size;
  logic [1:0] ecc_sel;
  logic busy, done, fail, rd_valid, ecc_en, ecc_dec, corr_start, flip_valid;
  logic [1:0] err_code;
  logic [COL_W-1:0] rd_col, flip_addr;
  logic [9:0] rd_len;
  logic rd_done, fifo_empty, dec_ready, corr_done, corr_fail;
  logic [23:0] ham_code, code_q;
  logic [31:0] bch_flags;
  logic [NPOS*16-1:0] bch_pos;
  logic [7:0] flip_mask;

  pgrd_ecc_seq #(.COL_W(COL_W), .NPOS(NPOS), .CLK_MHZ(1), .TIMEOUT_US(TMO)) u_pgrd_ecc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .page_size(page_size), .ecc_sel(ecc_sel),
    .bus16(bus16), .busy(busy), .done(done), .fail(fail), .err_code(err_code),
    .rd_valid(rd_valid), .rd_col(rd_col), .rd_len(rd_len), .rd_done(rd_done),
    .ecc_en(ecc_en), .ecc_dec(ecc_dec), .fifo_empty(fifo_empty), .ham_code(ham_code),
    .code_q(code_q), .dec_ready(dec_ready), .bch_flags(bch_flags), .bch_pos(bch_pos),
    .corr_start(corr_start), .corr_done(corr_done), .corr_fail(corr_fail),
    .flip_valid(flip_valid), .flip_addr(flip_addr), .flip_mask(flip_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int nchecks = 0, nerr = 0, cyc = 0;
  bit finished = 0;

  // per-sector stimulus
  logic [23:0]  ham_a  [16];
  bit           hfail_a[16];
  logic [31:0]  flg_a  [16];
  logic [127:0] pos_a  [16];
  int stall_step = -1, flag_dly = -1;
  bit is_bch = 0;

  // logs
  int rcol_l[64], rlen_l[64], n_rd;
  int faddr_l[256], fmask_l[256], n_fl;
  int n_done, n_fail, n_rise, cur_sec;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        summary();
      end
    end
  end

  function automatic int stride_of(input int sel, input bit wide);
    int b;
    b = (sel == 0) ? 3 : (sel == 2) ? 13 : 7;
    return b + (wide ? 1 : 0);
  endfunction

  // Responder: mover, ECC engine flags and Hamming corrector, all driven at falling edges
  initial begin
    bit mv_pend = 0, fe_pend = 0, dr_pend = 0, cr_pend = 0, prev_en = 0;
    int mv_cnt = 0, mv_len = 0, fe_cnt = 0, dr_cnt = 0, cr_cnt = 0;
    rd_done = 0; fifo_empty = 0; dec_ready = 0; corr_done = 0; corr_fail = 0;
    ham_code = '0; bch_flags = '0; bch_pos = '0;
    forever begin
      @(negedge clk);
      rd_done = 0; fifo_empty = 0; dec_ready = 0; corr_done = 0;
      ham_code = 24'($urandom);
      bch_flags = $urandom; bch_pos = {$urandom, $urandom, $urandom, $urandom};
      if (fe_pend) begin
        if (fe_cnt == 0) begin fifo_empty = 1; ham_code = ham_a[cur_sec]; fe_pend = 0; end
        else fe_cnt--;
      end
      if (dr_pend) begin
        if (dr_cnt == 0) begin
          dec_ready = 1; bch_flags = flg_a[cur_sec]; bch_pos = pos_a[cur_sec]; dr_pend = 0;
        end else dr_cnt--;
      end
      if (cr_pend) begin
        if (cr_cnt == 0) begin
          corr_done = 1; corr_fail = hfail_a[cur_sec]; cr_pend = 0;
          chk(code_q == ham_a[cur_sec], "R5 captured code", code_q, ham_a[cur_sec]);
        end else cr_cnt--;
      end
      if (mv_pend) begin
        if (mv_cnt == 0) begin
          rd_done = 1; mv_pend = 0;
          if (cur_sec != stall_step) begin
            if (mv_len == 512 && !is_bch) begin
              fe_pend = 1; fe_cnt = (flag_dly >= 0) ? flag_dly : int'($urandom % 6);
            end
            if (mv_len != 512 && is_bch) begin
              dr_pend = 1; dr_cnt = (flag_dly >= 0) ? flag_dly : int'($urandom % 6);
            end
          end
        end else mv_cnt--;
      end
      if (rd_valid && n_rd < 64) begin
        rcol_l[n_rd] = int'(rd_col); rlen_l[n_rd] = int'(rd_len); n_rd++;
        if (rd_len == 512) cur_sec++;
        mv_pend = 1; mv_len = int'(rd_len); mv_cnt = int'($urandom % 4);
      end
      if (corr_start) begin cr_pend = 1; cr_cnt = int'($urandom % 3); end
      if (flip_valid && n_fl < 256) begin
        faddr_l[n_fl] = int'(flip_addr); fmask_l[n_fl] = int'(flip_mask); n_fl++;
      end
      if (ecc_en && !prev_en) n_rise++;
      prev_en = ecc_en;
      if (done) n_done++;
      if (fail) n_fail++;
    end
  end

  // kind: 0 ok, 1 timeout at sector fs, 2 uncorrectable at fs, 3 Hamming fail at fs
  task automatic run_case(input int page, input int sel, input bit wide, input int kind,
                          input int fs, input bit restart, input int dly, input bit timing);
    int stv, nst, ne, nf, last_s, exp_err, ecnt;
    int ecol[64], elen[64], efa[256], efm[256];
    bit aborted;
    for (int s = 0; s < 16; s++) begin
      int found, cnt, unc;
      ham_a[s]   = 24'($urandom);
      hfail_a[s] = (kind == 3 && s == fs);
      unc   = (kind == 2 && s == fs) ? 1 : 0;
      found = unc ? 1 : int'($urandom % 2);
      cnt   = int'($urandom % 16);
      flg_a[s] = 32'(cnt << 4) | 32'(found << 1) | 32'(unc);
      pos_a[s] = {$urandom, $urandom, $urandom, $urandom};
    end
    stall_step = (kind == 1) ? fs : -1;
    flag_dly   = dly;
    is_bch     = (sel != 0);
    n_rd = 0; n_fl = 0; n_done = 0; n_fail = 0; n_rise = 0; cur_sec = -1;

    @(negedge clk);
    page_size = COL_W'(page); ecc_sel = 2'(sel); bus16 = wide; start = 1;
    @(negedge clk);
    start = 0;
    if (page < 512) chk(done == 1, "R2 done one cycle after start", done, 1);
    if (timing) begin
      chk(!rd_valid && !ecc_en, "R4 engine disabled before first sector", {rd_valid, ecc_en}, 0);
      @(negedge clk);
      chk(rd_valid && rd_col == 0 && rd_len == 512 && ecc_en,
          "R1 first data read two cycles after start", {rd_valid, rd_col}, {1'b1, 14'd0});
    end
    if (restart) begin
      repeat (4) @(negedge clk);
      page_size = COL_W'(512); ecc_sel = 2'b10; start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int t = 0; t < 20000 && (n_done + n_fail) == 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);

    // expected behaviour
    stv = stride_of(sel, wide);
    nst = page / 512;
    ne = 0; nf = 0; last_s = nst; aborted = 0;
    for (int s = 0; s < nst && !aborted; s++) begin
      ecol[ne] = s * 512; elen[ne] = 512; ne++;
      last_s = s + 1;
      if (kind == 1 && s == fs && sel == 0) begin aborted = 1; continue; end
      ecol[ne] = page + 2 + s * stv; elen[ne] = stv; ne++;
      if (kind != 0 && s == fs) begin aborted = 1; continue; end
      if (sel != 0 && flg_a[s][1]) begin
        ecnt = int'(flg_a[s][7:4]);
        if (ecnt > 8) ecnt = 8;
        for (int k = 0; k < ecnt; k++) begin
          int p;
          p = int'(pos_a[s][(k/2)*32 + (k%2)*16 +: 13]);
          if (p < 4096) begin efa[nf] = s * 512 + p / 8; efm[nf] = 1 << (p % 8); nf++; end
        end
      end
    end
    exp_err = aborted ? kind : 0;

    chk(n_rd == ne, "R1/R3 read request count", n_rd, ne);
    for (int i = 0; i < ne && i < n_rd; i++) begin
      if (elen[i] == 512)
        chk(rcol_l[i] == ecol[i] && rlen_l[i] == 512, "R1 data read column", rcol_l[i], ecol[i]);
      else
        chk(rcol_l[i] == ecol[i] && rlen_l[i] == elen[i], "R3 check-byte read column/stride",
            rcol_l[i] * 100 + rlen_l[i], ecol[i] * 100 + elen[i]);
    end
    chk(n_fl == nf, "R7 flip count", n_fl, nf);
    for (int i = 0; i < nf && i < n_fl; i++)
      chk(faddr_l[i] == efa[i] && fmask_l[i] == efm[i], "R7 flip address/mask",
          faddr_l[i] * 1000 + fmask_l[i], efa[i] * 1000 + efm[i]);
    chk(n_rise == ((page < 512) ? 0 : last_s), "R4 one engine enable per sector", n_rise,
        (page < 512) ? 0 : last_s);
    chk(ecc_dec == (sel != 0), "R4 decode direction", ecc_dec, sel != 0);
    chk(n_done == (aborted ? 0 : 1) && n_fail == (aborted ? 1 : 0),
        "R9 end pulses", n_done * 10 + n_fail, aborted ? 1 : 10);
    chk(!busy, "R9 idle after end", busy, 0);
    if (kind == 1) chk(err_code == 2'b01, "R8 timeout code", err_code, 1);
    else if (kind == 2) chk(err_code == 2'b10, "R6 uncorrectable code", err_code, 2);
    else if (kind == 3) chk(err_code == 2'b11, "R5 Hamming failure code", err_code, 3);
    else chk(err_code == 2'(exp_err), "R9 code held", err_code, exp_err);
    if (restart) chk(n_done == 1 && n_rd == ne, "R10 start while busy ignored", n_rd, ne);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; start = 0; page_size = '0; ecc_sel = '0; bus16 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !fail && !rd_valid && !ecc_en && !corr_start && !flip_valid &&
        err_code == 0, "R11 reset state",
        {busy, done, fail, rd_valid, ecc_en, corr_start, flip_valid, err_code}, 0);

    run_case(2048, 0, 0, 0, 0, 0, -1, 1);   // Hamming, 8-bit, timing
    run_case(4096, 0, 1, 0, 0, 0, -1, 0);   // Hamming, 16-bit
    run_case(2048, 1, 0, 0, 0, 0, -1, 1);   // BCH4
    run_case(4096, 2, 1, 0, 0, 0, -1, 0);   // BCH8 wide
    run_case(1024, 3, 1, 0, 0, 0, -1, 0);   // code 11 acts as BCH4
    run_case(8192, 2, 0, 0, 0, 0, -1, 0);   // 16 sectors
    run_case(256, 1, 0, 0, 0, 0, -1, 0);    // R2 short page
    run_case(1000, 0, 1, 0, 0, 0, -1, 0);   // R1 rounds down
    run_case(2048, 0, 0, 3, 1, 0, -1, 0);   // R5 Hamming fail
    run_case(4096, 2, 0, 2, 2, 0, -1, 0);   // R6 uncorrectable
    run_case(2048, 0, 0, 1, 0, 0, -1, 0);   // R8 Hamming timeout
    run_case(2048, 1, 1, 1, 1, 0, -1, 0);   // R8 BCH timeout
    run_case(1024, 0, 0, 0, 0, 0, TMO - 3, 0); // R8 late flag accepted
    run_case(1024, 2, 1, 0, 0, 0, TMO - 3, 0);
    run_case(2048, 1, 0, 0, 0, 1, -1, 0);   // R10 restart ignored
    for (int n = 0; n < 12; n++)
      run_case(int'($urandom % 17) * 512 + int'($urandom % 2) * 100, int'($urandom % 4),
               1'($urandom % 2), 0, 0, 0, -1, 0);
    summary();
  end
endmodule